// File: doc/BRIEF.md
# Dual-Mode Saturating Fractional Multiply-Accumulate Unit

This block is the arithmetic core for speech-codec kernels. Each cycle it can take two signed 16-bit fractional operands, form their doubled product (Q15 × Q15 → Q31), and add that product to a running accumulator or subtract it. The accumulator can also be cleared or loaded.

A mode input selects where saturation is applied. In per-step mode the running value is held to the signed 32-bit range after every accumulation. This matches codec arithmetic that saturates on each step. In guarded mode a 40-bit accumulator, with 8 guard bits, runs without clamping. Its value is clamped only when it is presented on the 32-bit result port. The two modes can produce different final results from the same operand sequence. Both are provided so that software can choose the one its reference vectors expect. Correction of an overflow needs no extra operation. A sticky flag records that some clamping took place.

Top module: `mac_sat_unit`

## Requirements
- R1: With `vld_i` high and `op_i` = 2'b00 (accumulate), the doubled signed product 2·a·b is added to the accumulator.
- R2: With `vld_i` high and `op_i` = 2'b01 (deduct), the doubled signed product is subtracted from the accumulator.
- R3: With `step_sat_i` = 1 (per-step mode), each accumulate or deduct result is clamped to 0x7FFFFFFF or 0x80000000 instead of wrapping. The accumulator is first clamped to 32 bits before it is used.
- R4: In per-step mode the product of 0x8000 and 0x8000 is clamped to 0x7FFFFFFF before it is added or subtracted.
- R5: With `step_sat_i` = 0 (guarded mode), the accumulator is 40 bits wide and wraps modulo 2^40. `result_o` always shows the accumulator clamped to the signed 32-bit range.
- R6: The same sequence of operations can end with different results in the two modes. One example is three accumulates of 0x7FFF·0x7FFF followed by three deducts of the same product: guarded mode returns to 0, while per-step mode does not.
- R7: `ovf_o` is sticky. It sets whenever clamping occurs: a product clamp, a pre-step clamp or a result clamp in per-step mode, or a new guarded accumulator value outside the 32-bit range. It stays set until a clear.
- R8: `op_i` = 2'b10 (clear) sets the accumulator to zero and drops `ovf_o`.
- R9: `op_i` = 2'b11 (load) sets the accumulator to the sign-extended 32-bit value {a_i, b_i} and leaves `ovf_o` unchanged.
- R10: `result_o` and `ovf_o` reflect an operation one clock edge after it is accepted. When `vld_i` is low, both hold their values whatever `op_i`, `a_i` and `b_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Operation strobe, one operation per cycle |
| op_i | input | 2 | 00 accumulate, 01 deduct, 10 clear, 11 load |
| step_sat_i | input | 1 | 1 = clamp every step, 0 = guarded accumulator |
| a_i | input | 16 | Signed operand A (load: upper half) |
| b_i | input | 16 | Signed operand B (load: lower half) |
| result_o | output | 32 | Accumulator clamped to signed 32 bits |
| ovf_o | output | 1 | Sticky clamp indicator |

## Verification
Every operation changes `result_o` and `ovf_o` at the first rising edge after it is presented. The bench drives each operation just after a falling edge, holds it across one rising edge, and compares both outputs at the next falling edge. At that point the registered result is settled and no input has changed yet. For hold behaviour the strobe is dropped while the other inputs carry a different operation, and the outputs are compared one edge later against their earlier values. The expected values come from an integer model of the two saturation modes that runs in step with the stimulus.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ACC  = 2'b00,
    OP_DED  = 2'b01,
    OP_CLR  = 2'b10,
    OP_LOAD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_clamp.sv
// Clamps a signed IW-bit value to signed OW bits and reports a clamp.
module mac_clamp #(
  parameter int IW = 40,
  parameter int OW = 32
) (
  input  logic [IW-1:0] val_i,
  output logic [OW-1:0] val_o,
  output logic          hit_o
);
  localparam int XW = IW - OW + 1;
  logic [XW-1:0] top_bits;

  always_comb begin
    top_bits = val_i[IW-1:OW-1];
    hit_o    = !((top_bits == '0) || (top_bits == '1));
    if (hit_o) val_o = val_i[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}};
    else       val_o = val_i[OW-1:0];
  end
endmodule

// File: rtl/mac_product.sv
// Doubled fractional product, optional clamp of the single overflowing case.
module mac_product #(
  parameter int OPW = 16,
  localparam int PW = 2 * OPW
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic           sat_en_i,
  output logic [PW:0]    prod_o,
  output logic           hit_o
);
  logic signed [PW-1:0] raw;
  logic        [PW:0]   dbl;

  always_comb begin
    raw   = $signed(a_i) * $signed(b_i);
    dbl   = {raw, 1'b0};
    hit_o = sat_en_i && (dbl[PW] != dbl[PW-1]);
    if (hit_o) prod_o = {2'b00, {(PW-1){1'b1}}};
    else       prod_o = dbl;
  end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
  parameter int OPW   = 16,
  parameter int GUARD = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [1:0]       op_i,
  input  logic             step_sat_i,
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  output logic [2*OPW-1:0] result_o,
  output logic             ovf_o
);
  import mac_pkg::*;

  localparam int PW = 2 * OPW;
  localparam int AW = PW + GUARD;
  localparam int SW = PW + 2;

  logic [AW-1:0] acc_q, acc_d;
  logic          ovf_q, ovf_d;
  logic          acc_en;

  logic [PW:0]   prod;
  logic          prod_hit;
  logic [PW-1:0] base;
  logic          base_hit;
  logic [SW-1:0] step_sum;
  logic [PW-1:0] step_res;
  logic          step_hit;
  logic [AW-1:0] grd_sum;
  logic [PW-1:0] nxt_view;
  logic          nxt_hit;
  logic          out_hit;
  mac_op_e       op;

  assign op = mac_op_e'(op_i);

  mac_product #(.OPW(OPW)) u_prod (
    .a_i(a_i), .b_i(b_i), .sat_en_i(step_sat_i),
    .prod_o(prod), .hit_o(prod_hit)
  );

  mac_clamp #(.IW(AW), .OW(PW)) u_base (
    .val_i(acc_q), .val_o(base), .hit_o(base_hit)
  );

  always_comb begin
    if (op == OP_DED)
      step_sum = {{2{base[PW-1]}}, base} - {prod[PW], prod};
    else
      step_sum = {{2{base[PW-1]}}, base} + {prod[PW], prod};
    if (op == OP_DED)
      grd_sum = acc_q - {{(AW-PW-1){prod[PW]}}, prod};
    else
      grd_sum = acc_q + {{(AW-PW-1){prod[PW]}}, prod};
  end

  mac_clamp #(.IW(SW), .OW(PW)) u_step (
    .val_i(step_sum), .val_o(step_res), .hit_o(step_hit)
  );

  // next-state
  always_comb begin
    acc_en = vld_i;
    acc_d  = acc_q;
    ovf_d  = ovf_q;
    case (op)
      OP_ACC, OP_DED: begin
        if (step_sat_i) begin
          acc_d = {{GUARD{step_res[PW-1]}}, step_res};
          ovf_d = ovf_q | prod_hit | base_hit | step_hit;
        end else begin
          acc_d = grd_sum;
          ovf_d = ovf_q | nxt_hit;
        end
      end
      OP_CLR: begin
        acc_d = '0;
        ovf_d = 1'b0;
      end
      default: acc_d = {{GUARD{a_i[OPW-1]}}, a_i, b_i};
    endcase
  end

  mac_clamp #(.IW(AW), .OW(PW)) u_chk (
    .val_i(grd_sum), .val_o(nxt_view), .hit_o(nxt_hit)
  );

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  mac_clamp #(.IW(AW), .OW(PW)) u_out (
    .val_i(acc_q), .val_o(result_o), .hit_o(out_hit)
  );

  assign ovf_o = ovf_q;

  // R8
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 2'b10) |=> (result_o == '0 && !ovf_o));

  // R7
  sticky_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !(vld_i && op_i == 2'b10)) |=> ovf_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(result_o) && $stable(ovf_o)));

  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && step_sat_i && !op_i[1]) |=>
      ((acc_q[AW-1:PW-1] == '0) || (acc_q[AW-1:PW-1] == '1)));

  // R9
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && op_i == 2'b11) |=> (result_o == $past({a_i, b_i}) && ovf_o == $past(ovf_o)));

  // R4
  min_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && step_sat_i && op_i == 2'b00 && a_i == {1'b1, {(OPW-1){1'b0}}}
      && b_i == {1'b1, {(OPW-1){1'b0}}}) |=> ovf_o);
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;
  localparam longint M40   = 64'sd1099511627776;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        vld_i;
  logic [1:0]  op_i;
  logic        step_sat_i;
  logic [15:0] a_i, b_i;
  logic [31:0] result_o;
  logic        ovf_o;

  int     n_chk = 0;
  int     n_bad = 0;
  longint m_acc = 0;
  bit     m_ovf = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mac_sat_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(vld_i), .op_i(op_i),
    .step_sat_i(step_sat_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .ovf_o(ovf_o)
  );

  function automatic longint clamp32(longint v);
    if (v > MAX32) return MAX32;
    if (v < MIN32) return MIN32;
    return v;
  endfunction

  task automatic check(string tag, longint exp_r, bit exp_o);
    n_chk++;
    if ($signed(result_o) != exp_r || ovf_o != exp_o) begin
      n_bad++;
      $display("FAIL %s: result=%0d ovf=%0d expected result=%0d ovf=%0d",
               tag, $signed(result_o), ovf_o, exp_r, exp_o);
    end
  endtask

  // model update, from the requirements
  task automatic model(logic [1:0] op, bit mode, logic [15:0] a, logic [15:0] b);
    longint p, s, base;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    case (op)
      2'b10: begin m_acc = 0; m_ovf = 1'b0; end
      2'b11: m_acc = longint'($signed({a, b}));
      default: begin
        if (mode) begin
          if (p > MAX32) begin p = MAX32; m_ovf = 1'b1; end
          base = clamp32(m_acc);
          if (base != m_acc) m_ovf = 1'b1;
          s = (op == 2'b01) ? base - p : base + p;
          if (clamp32(s) != s) m_ovf = 1'b1;
          m_acc = clamp32(s);
        end else begin
          s = (op == 2'b01) ? m_acc - p : m_acc + p;
          s = s & (M40 - 1);
          if (s >= M40 / 2) s = s - M40;
          if (clamp32(s) != s) m_ovf = 1'b1;
          m_acc = s;
        end
      end
    endcase
  endtask

  task automatic issue(logic [1:0] op, bit mode, logic [15:0] a, logic [15:0] b);
    @(negedge clk_i);
    vld_i = 1'b1; op_i = op; step_sat_i = mode; a_i = a; b_i = b;
    model(op, mode, a, b);
    @(negedge clk_i);
    vld_i = 1'b0;
  endtask

  logic [15:0] vals [9] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000,
                            16'h4000, 16'hC000, 16'h1234, 16'hF013};
  logic [31:0] loads [3] = '{32'h0000_0000, 32'h7FFF_FF00, 32'h8000_0100};

  initial begin
    vld_i = 1'b0; op_i = 2'b00; step_sat_i = 1'b0; a_i = '0; b_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("reset R8", 0, 1'b0);
    rst_ni = 1'b1;

    // sweep: R1 R2 R3 R5 R7 R9 across both modes, all pairs, several bases
    for (int md = 0; md < 2; md++)
      for (int li = 0; li < 3; li++)
        for (int ia = 0; ia < 9; ia++)
          for (int ib = 0; ib < 9; ib++) begin
            issue(2'b10, md[0], 16'h0, 16'h0);
            check("clear R8", m_acc, m_ovf);
            issue(2'b11, md[0], loads[li][31:16], loads[li][15:0]);
            check("load R9", clamp32(m_acc), m_ovf);
            issue(2'b00, md[0], vals[ia], vals[ib]);
            check(md ? "acc R1 R3" : "acc R1 R5", clamp32(m_acc), m_ovf);
            issue(2'b01, md[0], vals[ib], vals[ia]);
            check(md ? "ded R2 R3 R7" : "ded R2 R5 R7", clamp32(m_acc), m_ovf);
          end

    // R4 explicit corner
    issue(2'b10, 1'b1, 16'h0, 16'h0);
    issue(2'b00, 1'b1, 16'h8000, 16'h8000);
    check("R4 min*min", 64'sd2147483647, 1'b1);

    // R6 mode divergence, explicit literals
    issue(2'b10, 1'b0, 16'h0, 16'h0);
    for (int k = 0; k < 3; k++) issue(2'b00, 1'b0, 16'h7FFF, 16'h7FFF);
    for (int k = 0; k < 3; k++) issue(2'b01, 1'b0, 16'h7FFF, 16'h7FFF);
    check("R6 guarded returns", 0, 1'b1);
    issue(2'b10, 1'b1, 16'h0, 16'h0);
    for (int k = 0; k < 3; k++) issue(2'b00, 1'b1, 16'h7FFF, 16'h7FFF);
    for (int k = 0; k < 3; k++) issue(2'b01, 1'b1, 16'h7FFF, 16'h7FFF);
    check("R6 per-step diverges", m_acc, m_ovf);
    n_chk++;
    if (m_acc == 0 || result_o == 32'h0) begin
      n_bad++;
      $display("FAIL R6: result=%0d expected nonzero", $signed(result_o));
    end

    // R5 wrap at 40 bits
    issue(2'b10, 1'b0, 16'h0, 16'h0);
    issue(2'b11, 1'b0, 16'h7FFF, 16'hFFFF);
    for (int k = 0; k < 257; k++) issue(2'b00, 1'b0, 16'h8000, 16'h8000);
    check("R5 wrap", clamp32(m_acc), m_ovf);
    check("R5 wrapped negative", MIN32, 1'b1);

    // R7 sticky through load, R9 keeps flag
    issue(2'b11, 1'b0, 16'h0000, 16'h0005);
    check("R7 R9 sticky after load", 5, 1'b1);

    // R10 strobe low: outputs hold
    @(negedge clk_i);
    op_i = 2'b10; a_i = 16'h7FFF; b_i = 16'h7FFF; vld_i = 1'b0;
    @(negedge clk_i);
    check("R10 hold clear", 5, 1'b1);
    op_i = 2'b00;
    @(negedge clk_i);
    check("R10 hold acc", 5, 1'b1);

    // R10 latency: next edge shows new value
    issue(2'b00, 1'b1, 16'h0002, 16'h0003);
    check("R10 latency R1", 17, 1'b1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule